// File: doc/BRIEF.md
# FIFO Threshold Interrupt Generator

This block turns the fill counts of a UART's transmit and receive FIFOs into two level-sensitive interrupt requests. One asks for more transmit data. The other reports that received data is waiting. The block registers its inputs once per clock, and the requests are then decoded from that snapshot. Each request therefore follows its inputs one clock later and drops on its own once its condition no longer holds.

Two threshold schemes are available, chosen by a mode bit. In the legacy scheme, two-bit selector fields pick one of four fixed levels for each direction. In the enhanced scheme, software supplies 7-bit thresholds for each direction. A transmit threshold of zero in enhanced mode has a special meaning: the transmit request then waits until the FIFO is drained, the shift register is empty and the serial line has gone back to its idle (high) level. A small priority encoder reports which request is more urgent.

Top module: `uart_trig_irq`

## Requirements
- R1: While reset is asserted, and until the synchronised reset release has passed through the input register, `tx_irq`, `rx_irq` and `irq_any` are 0 and `irq_prio` is 0.
- R2: `tx_irq` is 0 whenever `ier_tx_en` was 0, and `rx_irq` is 0 whenever `ier_rx_en` was 0, in both modes.
- R3: With `enh_mode`=1, `rx_irq` is 1 exactly when `rx_level` >= `rx_thresh`. A threshold of 0 therefore always requests.
- R4: With `enh_mode`=1 and `tx_thresh` nonzero, `tx_irq` is 1 exactly when `tx_level` < `tx_thresh`.
- R5: With `enh_mode`=1 and `tx_thresh`=0, `tx_irq` is 1 only when three conditions all hold: `tx_level`=0, `tx_shift_empty`=1 and `sout_line`=1.
- R6: With `enh_mode`=0, `rx_irq` is 1 when `rx_level` reaches the level that `fcr_rx_sel` picks. The codes 0, 1, 2 and 3 pick 1, DEPTH/8, DEPTH/4 and DEPTH-DEPTH/8 characters. With DEPTH=128 these are 1, 16, 32 and 112.
- R7: With `enh_mode`=0, `tx_irq` is 1 when the free space (DEPTH-`tx_level`) is at least the level that `fcr_tx_sel` picks. The codes 0 to 3 pick 1, 16, 32 and 112 free entries for DEPTH=128.
- R8: In enhanced mode, `fcr_tx_sel` and `fcr_rx_sel` have no effect. In legacy mode, `tx_thresh`, `rx_thresh`, `tx_shift_empty` and `sout_line` have no effect.
- R9: `irq_prio` is 2 when `rx_irq` is 1, 3 when only `tx_irq` is 1, and 0 otherwise. `irq_any` is the OR of the two requests.
- R10: The outputs follow the inputs sampled at the previous rising clock edge. A request clears in the cycle after its condition fails, with no stickiness.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enh_mode | input | 1 | 1 selects programmable thresholds |
| ier_tx_en | input | 1 | Transmit request enable |
| ier_rx_en | input | 1 | Receive request enable |
| fcr_tx_sel | input | 2 | Legacy transmit level code |
| fcr_rx_sel | input | 2 | Legacy receive level code |
| tx_thresh | input | 7 | Enhanced transmit threshold |
| rx_thresh | input | 7 | Enhanced receive threshold |
| tx_level | input | 8 | Transmit FIFO fill count, 0..DEPTH |
| rx_level | input | 8 | Receive FIFO fill count, 0..DEPTH |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| sout_line | input | 1 | Serial output line, 1 is idle marking |
| tx_irq | output | 1 | Transmit data request |
| rx_irq | output | 1 | Receive data available |
| irq_any | output | 1 | Either request active |
| irq_prio | output | 2 | Winning priority level: 2, 3 or 0 |

## Verification
The assertions assume that both fill counts stay within 0..DEPTH. They also assume that every input is held steady across each rising edge, so that a value seen one edge back is the value the input register actually took. The stimulus changes inputs only on falling edges and draws fill counts from 0..DEPTH. The boundary values around each legacy level and each programmed threshold are included deliberately. Because the comparisons are made against values captured on the clock, a count that briefly goes out of range between edges is never observed.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    PRIO_NONE = 2'd0,
    PRIO_RX   = 2'd2,
    PRIO_TX   = 2'd3
  } irq_prio_e;

  // Fixed trigger level picked by a two-bit legacy code for a given depth.
  function automatic int legacy_level(input logic [1:0] code, input int depth);
    int lvl;
    case (code)
      2'd0:    lvl = 1;
      2'd1:    lvl = depth / 8;
      2'd2:    lvl = depth / 4;
      default: lvl = depth - depth / 8;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/trig_rst_sync.sv
module trig_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/trig_in_stage.sv
module trig_in_stage #(
  parameter int LVL_W = 8,
  parameter int THR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             enh_mode_i,
  input  logic             tx_en_i,
  input  logic             rx_en_i,
  input  logic [1:0]       tx_sel_i,
  input  logic [1:0]       rx_sel_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic [LVL_W-1:0] tx_lvl_i,
  input  logic [LVL_W-1:0] rx_lvl_i,
  input  logic             shift_empty_i,
  input  logic             line_i,
  output logic             enh_mode_q,
  output logic             tx_en_q,
  output logic             rx_en_q,
  output logic [1:0]       tx_sel_q,
  output logic [1:0]       rx_sel_q,
  output logic [THR_W-1:0] tx_thr_q,
  output logic [THR_W-1:0] rx_thr_q,
  output logic [LVL_W-1:0] tx_lvl_q,
  output logic [LVL_W-1:0] rx_lvl_q,
  output logic             shift_empty_q,
  output logic             line_q
);

  logic             enh_mode_d, tx_en_d, rx_en_d, shift_empty_d, line_d;
  logic [1:0]       tx_sel_d, rx_sel_d;
  logic [THR_W-1:0] tx_thr_d, rx_thr_d;
  logic [LVL_W-1:0] tx_lvl_d, rx_lvl_d;

  always_comb begin
    enh_mode_d    = enh_mode_q;
    tx_en_d       = tx_en_q;
    rx_en_d       = rx_en_q;
    tx_sel_d      = tx_sel_q;
    rx_sel_d      = rx_sel_q;
    tx_thr_d      = tx_thr_q;
    rx_thr_d      = rx_thr_q;
    tx_lvl_d      = tx_lvl_q;
    rx_lvl_d      = rx_lvl_q;
    shift_empty_d = shift_empty_q;
    line_d        = line_q;
    if (cap_en) begin
      enh_mode_d    = enh_mode_i;
      tx_en_d       = tx_en_i;
      rx_en_d       = rx_en_i;
      tx_sel_d      = tx_sel_i;
      rx_sel_d      = rx_sel_i;
      tx_thr_d      = tx_thr_i;
      rx_thr_d      = rx_thr_i;
      tx_lvl_d      = tx_lvl_i;
      rx_lvl_d      = rx_lvl_i;
      shift_empty_d = shift_empty_i;
      line_d        = line_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enh_mode_q    <= 1'b0;
      tx_en_q       <= 1'b0;
      rx_en_q       <= 1'b0;
      tx_sel_q      <= 2'd0;
      rx_sel_q      <= 2'd0;
      tx_thr_q      <= '0;
      rx_thr_q      <= '0;
      tx_lvl_q      <= '0;
      rx_lvl_q      <= '0;
      shift_empty_q <= 1'b0;
      line_q        <= 1'b0;
    end else begin
      enh_mode_q    <= enh_mode_d;
      tx_en_q       <= tx_en_d;
      rx_en_q       <= rx_en_d;
      tx_sel_q      <= tx_sel_d;
      rx_sel_q      <= rx_sel_d;
      tx_thr_q      <= tx_thr_d;
      rx_thr_q      <= rx_thr_d;
      tx_lvl_q      <= tx_lvl_d;
      rx_lvl_q      <= rx_lvl_d;
      shift_empty_q <= shift_empty_d;
      line_q        <= line_d;
    end
  end

endmodule

// File: rtl/trig_tx_eval.sv
module trig_tx_eval #(
  parameter int DEPTH = 128,
  parameter int LVL_W = 8,
  parameter int THR_W = 7
) (
  input  logic             enh_mode,
  input  logic             enable,
  input  logic [1:0]       sel,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  input  logic             shift_empty,
  input  logic             line_idle,
  output logic             req
);
  import trig_pkg::*;

  localparam int CW = LVL_W + 1;

  logic [CW-1:0] free_cnt;
  logic [CW-1:0] legacy_lvl;
  logic          legacy_hit;
  logic          drained;
  logic          enh_hit;

  always_comb begin
    free_cnt   = CW'(DEPTH) - CW'(level);
    legacy_lvl = CW'(legacy_level(sel, DEPTH));
    legacy_hit = (free_cnt >= legacy_lvl);
    drained    = (level == '0) && shift_empty && line_idle;
    if (thr == '0) enh_hit = drained;
    else           enh_hit = (CW'(level) < CW'(thr));
    req = enable && (enh_mode ? enh_hit : legacy_hit);
  end

endmodule

// File: rtl/trig_rx_eval.sv
module trig_rx_eval #(
  parameter int DEPTH = 128,
  parameter int LVL_W = 8,
  parameter int THR_W = 7
) (
  input  logic             enh_mode,
  input  logic             enable,
  input  logic [1:0]       sel,
  input  logic [THR_W-1:0] thr,
  input  logic [LVL_W-1:0] level,
  output logic             req
);
  import trig_pkg::*;

  localparam int CW = LVL_W + 1;

  logic [CW-1:0] legacy_lvl;
  logic          hit;

  always_comb begin
    legacy_lvl = CW'(legacy_level(sel, DEPTH));
    if (enh_mode) hit = (CW'(level) >= CW'(thr));
    else          hit = (CW'(level) >= legacy_lvl);
    req = enable && hit;
  end

endmodule

// File: rtl/trig_prio_enc.sv
module trig_prio_enc (
  input  logic       rx_req,
  input  logic       tx_req,
  output logic       any_req,
  output logic [1:0] prio
);
  import trig_pkg::*;

  irq_prio_e sel_prio;

  always_comb begin
    if (rx_req)      sel_prio = PRIO_RX;
    else if (tx_req) sel_prio = PRIO_TX;
    else             sel_prio = PRIO_NONE;
    prio    = sel_prio;
    any_req = rx_req | tx_req;
  end

endmodule

// File: rtl/uart_trig_irq.sv
module uart_trig_irq #(
  parameter int DEPTH = 128,
  parameter int THR_W = 7,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enh_mode,
  input  logic             ier_tx_en,
  input  logic             ier_rx_en,
  input  logic [1:0]       fcr_tx_sel,
  input  logic [1:0]       fcr_rx_sel,
  input  logic [THR_W-1:0] tx_thresh,
  input  logic [THR_W-1:0] rx_thresh,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_shift_empty,
  input  logic             sout_line,
  output logic             tx_irq,
  output logic             rx_irq,
  output logic             irq_any,
  output logic [1:0]       irq_prio
);

  logic             rst_sync_n;
  logic             enh_q, tx_en_q, rx_en_q, shift_empty_q, line_q;
  logic [1:0]       tx_sel_q, rx_sel_q;
  logic [THR_W-1:0] tx_thr_q, rx_thr_q;
  logic [LVL_W-1:0] tx_lvl_q, rx_lvl_q;

  trig_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  trig_in_stage #(.LVL_W(LVL_W), .THR_W(THR_W)) i_in_stage (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cap_en        (rst_sync_n),
    .enh_mode_i    (enh_mode),
    .tx_en_i       (ier_tx_en),
    .rx_en_i       (ier_rx_en),
    .tx_sel_i      (fcr_tx_sel),
    .rx_sel_i      (fcr_rx_sel),
    .tx_thr_i      (tx_thresh),
    .rx_thr_i      (rx_thresh),
    .tx_lvl_i      (tx_level),
    .rx_lvl_i      (rx_level),
    .shift_empty_i (tx_shift_empty),
    .line_i        (sout_line),
    .enh_mode_q    (enh_q),
    .tx_en_q       (tx_en_q),
    .rx_en_q       (rx_en_q),
    .tx_sel_q      (tx_sel_q),
    .rx_sel_q      (rx_sel_q),
    .tx_thr_q      (tx_thr_q),
    .rx_thr_q      (rx_thr_q),
    .tx_lvl_q      (tx_lvl_q),
    .rx_lvl_q      (rx_lvl_q),
    .shift_empty_q (shift_empty_q),
    .line_q        (line_q)
  );

  trig_tx_eval #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) i_tx_eval (
    .enh_mode    (enh_q),
    .enable      (tx_en_q),
    .sel         (tx_sel_q),
    .thr         (tx_thr_q),
    .level       (tx_lvl_q),
    .shift_empty (shift_empty_q),
    .line_idle   (line_q),
    .req         (tx_irq)
  );

  trig_rx_eval #(.DEPTH(DEPTH), .LVL_W(LVL_W), .THR_W(THR_W)) i_rx_eval (
    .enh_mode (enh_q),
    .enable   (rx_en_q),
    .sel      (rx_sel_q),
    .thr      (rx_thr_q),
    .level    (rx_lvl_q),
    .req      (rx_irq)
  );

  trig_prio_enc i_prio (
    .rx_req  (rx_irq),
    .tx_req  (tx_irq),
    .any_req (irq_any),
    .prio    (irq_prio)
  );

  // R2: a request needs its enable at the sampling edge
  assert_tx_gated_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_irq |-> $past(ier_tx_en));
  assert_rx_gated_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_irq |-> $past(ier_rx_en));

  // R3: enhanced receive request implies the count had reached the threshold
  assert_rx_thresh_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_irq && $past(enh_mode)) |-> ($past(rx_level) >= LVL_W'($past(rx_thresh))));

  // R5: zero transmit threshold fires only on a fully drained, idle transmitter
  assert_tx_drained_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_irq && $past(enh_mode) && ($past(tx_thresh) == '0)) |->
      ($past(tx_level) == '0 && $past(tx_shift_empty) && $past(sout_line)));

  // R9: the reported level never disagrees with the active requests
  assert_prio_rx_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_irq |-> (irq_prio == 2'd2 && irq_any));
  assert_prio_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !irq_any |-> (irq_prio == 2'd0 && !tx_irq && !rx_irq));

  // R1: nothing is requested while the synchronised reset is held
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!irq_any && irq_prio == 2'd0));

endmodule

// File: tb/test_uart_trig_irq.sv
`timescale 1ns/1ps
module test_uart_trig_irq;

  localparam int DEPTH = 128;

  logic       clk;
  logic       rst_n;
  logic       enh_mode, ier_tx_en, ier_rx_en, tx_shift_empty, sout_line;
  logic [1:0] fcr_tx_sel, fcr_rx_sel;
  logic [6:0] tx_thresh, rx_thresh;
  logic [7:0] tx_level, rx_level;
  logic       tx_irq, rx_irq, irq_any;
  logic [1:0] irq_prio;

  int    n_chk;
  int    n_bad;
  string tag;

  uart_trig_irq i_uart_trig_irq (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .ier_tx_en(ier_tx_en),
    .ier_rx_en(ier_rx_en), .fcr_tx_sel(fcr_tx_sel), .fcr_rx_sel(fcr_rx_sel),
    .tx_thresh(tx_thresh), .rx_thresh(rx_thresh), .tx_level(tx_level),
    .rx_level(rx_level), .tx_shift_empty(tx_shift_empty), .sout_line(sout_line),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .irq_any(irq_any), .irq_prio(irq_prio)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference snapshot: inputs seen at the last edge, valid from the third
  // edge after reset release (two synchroniser stages, then capture).
  int m_edges, m_valid;
  int s_enh, s_te, s_re, s_ts, s_rs, s_tt, s_rt, s_tl, s_rl, s_se, s_so;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_edges = 0;
      m_valid = 0;
    end else begin
      m_edges = m_edges + 1;
      if (m_edges >= 3) begin
        m_valid = 1;
        s_enh = enh_mode; s_te = ier_tx_en; s_re = ier_rx_en;
        s_ts = fcr_tx_sel; s_rs = fcr_rx_sel; s_tt = tx_thresh; s_rt = rx_thresh;
        s_tl = tx_level; s_rl = rx_level; s_se = tx_shift_empty; s_so = sout_line;
      end
    end
  end

  function automatic int fixed_level(int code);
    case (code)
      0: return 1;
      1: return 16;
      2: return 32;
      default: return 112;
    endcase
  endfunction

  function automatic logic [4:0] expected();
    int t, r, p;
    t = 0; r = 0; p = 0;
    if (m_valid != 0) begin
      if (s_enh != 0) begin
        r = (s_rl >= s_rt) ? 1 : 0;
        if (s_tt == 0) t = (s_tl == 0 && s_se != 0 && s_so != 0) ? 1 : 0;
        else           t = (s_tl < s_tt) ? 1 : 0;
      end else begin
        r = (s_rl >= fixed_level(s_rs)) ? 1 : 0;
        t = ((DEPTH - s_tl) >= fixed_level(s_ts)) ? 1 : 0;
      end
      if (s_te == 0) t = 0;
      if (s_re == 0) r = 0;
      p = (r != 0) ? 2 : ((t != 0) ? 3 : 0);
    end
    return {t[0], r[0], (t[0] | r[0]), p[1:0]};
  endfunction

  task automatic cyc();
    logic [4:0] exp_v, act_v;
    @(negedge clk);
    exp_v = expected();
    act_v = {tx_irq, rx_irq, irq_any, irq_prio};
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s t=%0t {tx,rx,any,prio} actual=%b expected=%b", tag, $time, act_v, exp_v);
    end
  endtask

  task automatic set_all(input int em, input int te, input int re, input int ts, input int rs,
                         input int tt, input int rt, input int tl, input int rl,
                         input int se, input int so);
    enh_mode = em[0]; ier_tx_en = te[0]; ier_rx_en = re[0];
    fcr_tx_sel = ts[1:0]; fcr_rx_sel = rs[1:0];
    tx_thresh = tt[6:0]; rx_thresh = rt[6:0];
    tx_level = tl[7:0]; rx_level = rl[7:0];
    tx_shift_empty = se[0]; sout_line = so[0];
  endtask

  int edge_lv[12] = '{0, 1, 15, 16, 17, 31, 32, 33, 96, 111, 112, 128};

  initial begin
    #20000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    tag = "R1";
    rst_n = 1'b0;
    // R1: everything active, yet reset must hold the outputs low
    set_all(1, 1, 1, 0, 0, 5, 0, 0, 100, 1, 1);
    for (int i = 0; i < 4; i++) cyc();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();

    // R3: enhanced receive threshold around its boundary
    tag = "R3";
    for (int i = 0; i < 40; i++) begin
      int rt, rl;
      rt = $urandom_range(0, 127);
      case (i % 4)
        0: rl = (rt > 0) ? rt - 1 : 0;
        1: rl = rt;
        2: rl = rt + 1;
        default: rl = $urandom_range(0, DEPTH);
      endcase
      set_all(1, 0, 1, 0, 0, 1, rt, 0, rl, 0, 0);
      cyc();
    end

    // R4: enhanced nonzero transmit threshold
    tag = "R4";
    for (int i = 0; i < 40; i++) begin
      int tt, tl;
      tt = $urandom_range(1, 127);
      case (i % 3)
        0: tl = tt - 1;
        1: tl = tt;
        default: tl = $urandom_range(0, DEPTH);
      endcase
      set_all(1, 1, 0, 0, 0, tt, 0, tl, 0, $urandom_range(0, 1), $urandom_range(0, 1));
      cyc();
    end

    // R5: zero transmit threshold, every combination of level/shift/line
    tag = "R5";
    for (int i = 0; i < 16; i++) begin
      set_all(1, 1, 0, 0, 0, 0, 0, (i & 1) ? 1 + (i >> 3) : 0, 0, (i >> 1) & 1, (i >> 2) & 1);
      cyc();
    end

    // R6 and R7: legacy codes against fill counts at their edges
    for (int s = 0; s < 4; s++) begin
      for (int k = 0; k < 12; k++) begin
        tag = "R6";
        set_all(0, 0, 1, 0, s, 0, 0, 0, edge_lv[k], 0, 0);
        cyc();
        tag = "R7";
        set_all(0, 1, 0, s, 0, 0, 0, edge_lv[k], 0, 0, 0);
        cyc();
      end
    end

    // R8: fields of the unused scheme toggle freely
    tag = "R8";
    for (int i = 0; i < 60; i++) begin
      set_all(i & 1, 1, 1, $urandom_range(0, 3), $urandom_range(0, 3),
              $urandom_range(0, 127), $urandom_range(0, 127),
              $urandom_range(0, DEPTH), $urandom_range(0, DEPTH),
              $urandom_range(0, 1), $urandom_range(0, 1));
      cyc();
    end

    // R2: enables masked in both modes
    tag = "R2";
    for (int i = 0; i < 40; i++) begin
      set_all($urandom_range(0, 1), (i >> 1) & 1, i & 1, $urandom_range(0, 3), $urandom_range(0, 3),
              $urandom_range(0, 127), $urandom_range(0, 127),
              $urandom_range(0, DEPTH), $urandom_range(0, DEPTH),
              $urandom_range(0, 1), $urandom_range(0, 1));
      cyc();
    end

    // R9: both requests together, then transmit alone, then none
    tag = "R9";
    set_all(1, 1, 1, 0, 0, 10, 5, 2, 50, 0, 0); cyc();
    set_all(1, 1, 1, 0, 0, 10, 5, 2, 1, 0, 0);  cyc();
    set_all(1, 1, 1, 0, 0, 10, 5, 90, 1, 0, 0); cyc();

    // R10: condition alternating each cycle, request must follow and clear
    tag = "R10";
    for (int i = 0; i < 12; i++) begin
      set_all(1, 1, 1, 0, 0, 20, 40, (i & 1) ? 19 : 20, (i & 1) ? 40 : 39, 0, 0);
      cyc();
    end

    // R1: reset reasserted in mid-run clears outputs
    tag = "R1";
    set_all(1, 1, 1, 0, 0, 20, 0, 0, 10, 1, 1);
    cyc();
    rst_n = 1'b0;
    cyc();
    cyc();
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule